// File: doc/BRIEF.md
# Misaligned Access Bus Splitter

This block accepts one load or store from the processor side: a byte address, a data size (byte, halfword or word) and, for stores, 32 bits of write data. Data of any size may sit at any byte address. The block never raises a fault. It turns each request into the naturally aligned external bus cycles needed to move the data, one after another in ascending address order. Each cycle carries its own address, size code and byte-lane enables, and waits on a simple request/acknowledge handshake.

For loads, the block gathers the returned pieces into one little-endian, right-justified result. For stores, it routes the right bytes of the write data onto the enabled lanes of each cycle. The processor side receives a single one-cycle completion pulse once the last bus cycle has been acknowledged.

The control is a three-state machine:
- `ST_IDLE` takes a request and moves to `ST_ISSUE`.
- `ST_ISSUE` drives one bus cycle at a time. On each acknowledge it advances the address, the byte count and the data. The acknowledge of the final piece moves it to `ST_DONE`.
- `ST_DONE` raises the completion pulse for one cycle and returns to `ST_IDLE`.

Top module: `mis_split`

## Requirements
- R1: Size code 00 is a byte, 01 a halfword and 10 a word, on both `cpu_size` and `bus_size`. A byte access, a halfword at an even address and a word at an address whose low two bits are 00 each become exactly one bus cycle of the same size at the same address.
- R2: A halfword at an odd address becomes two byte cycles, at A and then A+1.
- R3: A word whose low two address bits are 10 becomes two halfword cycles, at A and then A+2.
- R4: A word at an odd address becomes three cycles: a byte at A, a halfword at A+1 and a byte at A+3.
- R5: Each bus cycle after the first starts at the previous cycle's address plus the previous cycle's size in bytes, wrapping modulo 2^ADDR_W. Every bus address is aligned to its own size.
- R6: For a cycle of N bytes at address S, `bus_be` bit k is set exactly for lanes S[1:0] to S[1:0]+N-1. Data is little-endian: the first cycle carries the least significant bytes of `cpu_wdata`, and each byte goes out on the lane equal to its address modulo 4.
- R7: On a load of N bytes, `cpu_rdata` byte k holds the byte read from address A+k, taken from lane (A+k) mod 4. Bytes at positions N and above are zero. A store returns zero on `cpu_rdata`.
- R8: `cpu_done` is high for exactly one cycle per request, in the cycle after the final acknowledge is sampled, with `bus_req` low.
- R9: `cpu_req` is ignored in `ST_ISSUE` and `ST_DONE`. It neither changes the running sequence nor starts another one.
- R10: After reset, `bus_req` and `cpu_done` are low.
- R11: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_addr`, `bus_size` and `bus_be` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Request strobe, sampled in `ST_IDLE` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_size | input | 2 | 00 byte, 01 halfword, 10 word |
| cpu_wdata | input | 32 | Store data, right-justified |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load result, right-justified, valid with `cpu_done` |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | Bus cycle direction |
| bus_addr | output | ADDR_W | Aligned bus cycle address |
| bus_size | output | 2 | Bus cycle size code |
| bus_be | output | 4 | Byte-lane enables |
| bus_wdata | output | 32 | Lane-steered store data |
| bus_ack | input | 1 | Bus cycle acknowledge |
| bus_rdata | input | 32 | Full-width lane data returned by the bus |

## Verification
The bench builds the block with ADDR_W = 8. With that width, the address wrap from 0xFF back to 0x00 falls inside ordinary word accesses at 0xFE and 0xFF, so the carry through the address advance is checked for both the halfword-halfword and the byte-halfword-byte splits. The small 256-byte bus model used by the responder covers every lane alignment at many base addresses. That model returns real data on disabled lanes as well, so any failure to mask a read piece shows up in the merged result. Responder wait states of 0 to 3 cycles, and a stray request raised mid-sequence, test the hold behaviour and the refusal of new work while busy.

// File: rtl/ms_pkg.sv
package ms_pkg;
    localparam int MS_DW    = 32;
    localparam int MS_LANES = MS_DW / 8;
    localparam int LB       = $clog2(MS_LANES);
    localparam int CW       = LB + 1;

    typedef enum logic [1:0] {
        SZ_B = 2'b00,
        SZ_H = 2'b01,
        SZ_W = 2'b10
    } ms_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ISSUE = 2'b01,
        ST_DONE  = 2'b10
    } ms_state_e;
endpackage

// File: rtl/ms_plan.sv
// Picks the next piece: the largest size the current address is aligned to
// that still fits inside the bytes left to move.
module ms_plan
    import ms_pkg::*;
(
    input  logic [LB-1:0] lo,
    input  logic [CW-1:0] rem,
    output ms_size_e      sz,
    output logic [CW-1:0] nb
);
    always_comb begin
        if (lo == '0 && rem >= CW'(4)) begin
            sz = SZ_W;
        end else if (!lo[0] && rem >= CW'(2)) begin
            sz = SZ_H;
        end else begin
            sz = SZ_B;
        end
        nb = CW'(1) << sz;
    end
endmodule

// File: rtl/ms_lane.sv
// Byte-lane steering for one piece: enables, write routing, read extraction.
module ms_lane
    import ms_pkg::*;
(
    input  logic [LB-1:0]       lo,
    input  logic [CW-1:0]       nb,
    input  logic [MS_DW-1:0]    wpend,
    input  logic [MS_DW-1:0]    rraw,
    output logic [MS_LANES-1:0] be,
    output logic [MS_DW-1:0]    wlanes,
    output logic [MS_DW-1:0]    rpiece
);
    for (genvar i = 0; i < MS_LANES; i++) begin : g_lane
        logic [CW-1:0] rel;
        logic [LB-1:0] src;
        assign rel   = CW'(i) - CW'(lo);
        assign src   = LB'(i) + lo;
        assign be[i] = rel < nb;
        assign wlanes[8*i +: 8] = be[i] ? wpend[{rel[LB-1:0], 3'b000} +: 8] : 8'h00;
        assign rpiece[8*i +: 8] = (CW'(i) < nb) ? rraw[{src, 3'b000} +: 8] : 8'h00;
    end
endmodule

// File: rtl/mis_split.sv
module mis_split
    import ms_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic [MS_DW-1:0]  cpu_wdata,
    output logic              cpu_done,
    output logic [MS_DW-1:0]  cpu_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [MS_LANES-1:0] bus_be,
    output logic [MS_DW-1:0]  bus_wdata,
    input  logic              bus_ack,
    input  logic [MS_DW-1:0]  bus_rdata
);
    ms_state_e          st, st_nx;
    logic [ADDR_W-1:0]  addr_q;
    logic [CW-1:0]      rem_q;
    logic [CW-1:0]      off_q;
    logic [MS_DW-1:0]   wbuf;
    logic [MS_DW-1:0]   rbuf;
    logic               we_q;

    ms_size_e           sz;
    logic [CW-1:0]      nb;
    logic [MS_LANES-1:0] be;
    logic [MS_DW-1:0]   wlanes;
    logic [MS_DW-1:0]   rpiece;
    logic [CW-1:0]      req_bytes;
    logic               accept;
    logic               step;
    logic               last;

    ms_plan u_plan (
        .lo  (addr_q[LB-1:0]),
        .rem (rem_q),
        .sz  (sz),
        .nb  (nb)
    );

    ms_lane u_lane (
        .lo     (addr_q[LB-1:0]),
        .nb     (nb),
        .wpend  (wbuf),
        .rraw   (bus_rdata),
        .be     (be),
        .wlanes (wlanes),
        .rpiece (rpiece)
    );

    always_comb begin
        unique case (cpu_size)
            2'b00:   req_bytes = CW'(1);
            2'b01:   req_bytes = CW'(2);
            default: req_bytes = CW'(MS_LANES);
        endcase
    end

    assign accept = (st == ST_IDLE) && cpu_req;
    assign step   = (st == ST_ISSUE) && bus_ack;
    assign last   = (rem_q == nb);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Transitions: IDLE->ISSUE on request, ISSUE->DONE on final ack, DONE->IDLE
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (cpu_req) st_nx = ST_ISSUE;
            ST_ISSUE: if (bus_ack && last) st_nx = ST_DONE;
            ST_DONE:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bus_req   = (st == ST_ISSUE);
        cpu_done  = (st == ST_DONE);
        bus_we    = we_q;
        bus_addr  = addr_q;
        bus_size  = sz;
        bus_be    = be;
        bus_wdata = wlanes;
        cpu_rdata = rbuf;
    end

    // Request datapath: address, remaining count, data shifting and merging
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
            off_q  <= '0;
            wbuf   <= '0;
            rbuf   <= '0;
            we_q   <= 1'b0;
        end else if (accept) begin
            addr_q <= cpu_addr;
            rem_q  <= req_bytes;
            off_q  <= '0;
            wbuf   <= cpu_wdata;
            rbuf   <= '0;
            we_q   <= cpu_we;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(nb);
            rem_q  <= rem_q - nb;
            off_q  <= off_q + nb;
            wbuf   <= wbuf >> {nb, 3'b000};
            if (!we_q) begin
                rbuf <= rbuf | (rpiece << {off_q[LB-1:0], 3'b000});
            end
        end
    end
endmodule

// File: rtl/ms_split_chk.sv
module ms_split_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [3:0]        bus_be,
    input logic              cpu_done
);
    logic [ADDR_W-1:0] step_bytes;
    assign step_bytes = ADDR_W'(1) << bus_size;

    a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_size) && $stable(bus_be));

    a_r5_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack |=> !bus_req || bus_addr == $past(bus_addr + step_bytes));

    a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr[1:0] & 2'((3'd1 << bus_size) - 3'd1)) == 2'd0);

    a_r6_lanes_match_size: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> $countones(bus_be) == (32'd1 << bus_size) && bus_be[bus_addr[1:0]]);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> $past(bus_req && bus_ack) && !bus_req);
endmodule

bind mis_split ms_split_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .bus_be   (bus_be),
    .cpu_done (cpu_done)
);

// File: tb/sim_mis_split.sv
module sim_mis_split;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_done;
    logic [31:0] cpu_rdata;
    logic        bus_req;
    logic        bus_we;
    logic [7:0]  bus_addr;
    logic [1:0]  bus_size;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int fails = 0;
    int done_cnt = 0;
    int resp_wait = 0;
    logic [7:0] mem [256];

    logic [7:0]  ea_q [$];
    logic [1:0]  es_q [$];
    logic [3:0]  eb_q [$];
    logic [31:0] ew_q [$];
    logic        ewe_q [$];
    string       tag_q [$];
    logic [31:0] erd_q [$];
    string       rtag_q [$];

    always #5 clk = ~clk;

    mis_split #(.ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string tg, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tg, got, exp);
        end
    endtask

    // Bus responder with a word-organised byte memory
    initial begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        forever begin
            @(negedge clk);
            #1;
            if (bus_ack) begin
                bus_ack = 1'b0;
                cnt = 0;
            end else if (bus_req) begin
                if (cnt >= resp_wait) begin
                    for (int i = 0; i < 4; i++) begin
                        bus_rdata[8*i +: 8] = mem[{bus_addr[7:2], 2'(i)}];
                        if (bus_we && bus_be[i]) mem[{bus_addr[7:2], 2'(i)}] = bus_wdata[8*i +: 8];
                    end
                    bus_ack = 1'b1;
                end else begin
                    cnt++;
                end
            end
        end
    end

    // Monitor: pops expected sub-cycles and results as they appear
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (bus_req && bus_ack) begin
                if (ea_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected bus cycle", 32'(bus_addr), 32'hFFFF_FFFF);
                end else begin
                    logic [7:0] ea; logic [1:0] es; logic [3:0] eb; logic [31:0] ew; logic ewe; string tg;
                    logic wok;
                    ea = ea_q.pop_front(); es = es_q.pop_front(); eb = eb_q.pop_front();
                    ew = ew_q.pop_front(); ewe = ewe_q.pop_front(); tg = tag_q.pop_front();
                    chk(bus_addr == ea, {tg, " addr"}, 32'(bus_addr), 32'(ea));
                    chk(bus_size == es, {tg, " size"}, 32'(bus_size), 32'(es));
                    chk(bus_be == eb, {tg, " R6 lanes"}, 32'(bus_be), 32'(eb));
                    chk(bus_we == ewe, {tg, " dir"}, 32'(bus_we), 32'(ewe));
                    wok = 1'b1;
                    for (int i = 0; i < 4; i++)
                        if (ewe && eb[i] && bus_wdata[8*i +: 8] != ew[8*i +: 8]) wok = 1'b0;
                    chk(wok, {tg, " R6 wdata"}, bus_wdata, ew);
                end
            end
            if (cpu_done) begin
                done_cnt++;
                chk(ea_q.size() == 0, "R8 done before final cycle", 32'(ea_q.size()), 32'd0);
                chk(!bus_req, "R8 bus_req with done", 32'(bus_req), 32'd0);
                if (erd_q.size() != 0) begin
                    logic [31:0] er; string rt;
                    er = erd_q.pop_front(); rt = rtag_q.pop_front();
                    chk(cpu_rdata == er, {rt, " R7 rdata"}, cpu_rdata, er);
                end
            end
        end
    end

    task automatic push_sub(input logic [7:0] sa, input int n, input int off,
                            input logic we, input logic [31:0] wd, input string tg);
        logic [31:0] lanes;
        lanes = '0;
        for (int j = 0; j < n; j++) lanes[8*(int'(sa[1:0]) + j) +: 8] = wd[8*(off + j) +: 8];
        ea_q.push_back(sa);
        es_q.push_back(n == 1 ? 2'b00 : (n == 2 ? 2'b01 : 2'b10));
        eb_q.push_back(4'(((1 << n) - 1) << sa[1:0]));
        ew_q.push_back(lanes);
        ewe_q.push_back(we);
        tag_q.push_back(tg);
    endtask

    // Driver: expected pieces come from the split rules stated per size/alignment
    task automatic access(input logic we, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input int waits, input bit poke, input string tg);
        int n; int d0; int guard; logic [31:0] er;
        n = (sz == 2'b00) ? 1 : (sz == 2'b01 ? 2 : 4);
        case (sz)
            2'b00: push_sub(a, 1, 0, we, wd, tg);
            2'b01: if (!a[0]) push_sub(a, 2, 0, we, wd, tg);
                   else begin push_sub(a, 1, 0, we, wd, tg); push_sub(8'(a + 1), 1, 1, we, wd, tg); end
            default:
                if (a[1:0] == 2'b00) push_sub(a, 4, 0, we, wd, tg);
                else if (a[1:0] == 2'b10) begin
                    push_sub(a, 2, 0, we, wd, tg); push_sub(8'(a + 2), 2, 2, we, wd, tg);
                end else begin
                    push_sub(a, 1, 0, we, wd, tg); push_sub(8'(a + 1), 2, 1, we, wd, tg);
                    push_sub(8'(a + 3), 1, 3, we, wd, tg);
                end
        endcase
        er = '0;
        if (!we) for (int k = 0; k < n; k++) er[8*k +: 8] = mem[8'(a + k)];
        erd_q.push_back(er);
        rtag_q.push_back(tg);
        resp_wait = waits;
        d0 = done_cnt;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        if (poke) begin
            @(negedge clk);
            cpu_req = 1'b1; cpu_we = ~we; cpu_addr = 8'hC4; cpu_size = 2'b00; cpu_wdata = 32'hDEAD_BEEF;
            @(negedge clk);
            cpu_req = 1'b0;
        end
        guard = 0;
        while (done_cnt == d0 && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
        #4;
        chk(done_cnt == d0 + 1, {tg, " R8 one done per request"}, 32'(done_cnt - d0), 32'd1);
        chk(ea_q.size() == 0, {tg, " R9 pieces outstanding"}, 32'(ea_q.size()), 32'd0);
        chk(!bus_req, {tg, " R9 no extra cycle"}, 32'(bus_req), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        #4;
        chk(!bus_req, "R10 bus_req in reset", 32'(bus_req), 32'd0);
        chk(!cpu_done, "R10 done in reset", 32'(cpu_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #4;
        chk(!bus_req && !cpu_done, "R10 idle after reset", 32'({bus_req, cpu_done}), 32'd0);

        access(1'b0, 8'h13, 2'b00, '0, 0, 1'b0, "R1");            // R1 byte
        access(1'b0, 8'h20, 2'b01, '0, 0, 1'b0, "R1");            // R1 aligned half
        access(1'b0, 8'h30, 2'b10, '0, 1, 1'b0, "R1");            // R1 aligned word
        access(1'b1, 8'h34, 2'b10, 32'h1122_3344, 0, 1'b0, "R1");
        access(1'b0, 8'h21, 2'b01, '0, 0, 1'b0, "R2");            // R2 odd half
        access(1'b1, 8'h23, 2'b01, 32'h0000_A55A, 1, 1'b0, "R2");
        access(1'b0, 8'h42, 2'b10, '0, 0, 1'b0, "R3");            // R3 halves
        access(1'b1, 8'h46, 2'b10, 32'h0F1E_2D3C, 0, 1'b0, "R3");
        access(1'b0, 8'h51, 2'b10, '0, 0, 1'b0, "R4");            // R4 byte/half/byte
        access(1'b0, 8'h53, 2'b10, '0, 2, 1'b0, "R4");
        access(1'b1, 8'h61, 2'b10, 32'hA1B2_C3D4, 0, 1'b0, "R6"); // R6 lane steering
        chk({mem[8'h64], mem[8'h63], mem[8'h62], mem[8'h61]} == 32'hA1B2_C3D4,
            "R6 stored bytes", {mem[8'h64], mem[8'h63], mem[8'h62], mem[8'h61]}, 32'hA1B2_C3D4);
        chk(mem[8'h60] == 8'(8'h60 * 37 + 11) && mem[8'h65] == 8'(8'h65 * 37 + 11),
            "R6 neighbours untouched", {16'h0, mem[8'h60], mem[8'h65]},
            {16'h0, 8'(8'h60 * 37 + 11), 8'(8'h65 * 37 + 11)});
        access(1'b0, 8'h60, 2'b10, '0, 0, 1'b0, "R7");            // R7 merged result
        access(1'b0, 8'h65, 2'b01, '0, 0, 1'b0, "R7");            // R7 upper bytes zero
        access(1'b0, 8'h62, 2'b00, '0, 1, 1'b0, "R7");
        access(1'b0, 8'hFE, 2'b10, '0, 0, 1'b0, "R5");            // R5 wrap, halves
        access(1'b0, 8'hFF, 2'b10, '0, 1, 1'b0, "R5");            // R5 wrap, byte/half/byte
        access(1'b0, 8'h71, 2'b10, '0, 3, 1'b0, "R11");           // R11 wait states
        access(1'b1, 8'h81, 2'b10, 32'h5566_7788, 2, 1'b1, "R9"); // R9 request while busy
        access(1'b0, 8'h81, 2'b10, '0, 0, 1'b0, "R9");
        chk(cpu_rdata == 32'h5566_7788, "R9 stray request left data intact", cpu_rdata, 32'h5566_7788);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule